// File: doc/BRIEF.md
# Two-Wire Register Target with Address Auto-Increment

This block is a two-wire serial bus target that gives a host read and write access to a register file of 16-bit words with 16-bit addresses. A transfer opens with START and an address byte whose top seven bits must match the `DEV_ADDR` parameter. Two bytes then set the register pointer, high byte first. Data words follow as two bytes each, also high byte first. Every byte the target receives is acknowledged by pulling the data line low. Readback uses the same data line. The host sets the pointer in a write phase, issues a repeated START with the read bit set, clocks out as many words as it wants, and NACKs the low byte of the last word.

Bursts go to consecutive registers while the auto-increment control bit is set. That bit is bit 0 of the register at `CTRL_ADDR`, and it is 1 after reset. When it is cleared, every word of a burst goes to, or comes from, the same register. A strap input chooses the interface: the block works only while the strap is low. Both bus lines pass through two-flop synchronizers, and the block samples them with its own clock. The register-file side is a plain port: an address, write data, a one-cycle write strobe and combinational read data.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset the data-line pull-down is released, the register pointer reads 0, no write strobe is active and auto-increment is enabled.
- R2: An address byte whose upper seven bits differ from `DEV_ADDR` gets a NACK (line left high). The target then ignores every byte, acks nothing and writes nothing until the next START or STOP.
- R3: In a write, the address byte (bit 0 = 0), the pointer high and low bytes and each data byte are acked. Each complete data word raises `reg_we_o` for exactly one cycle, with the word (first byte in bits 15:8) on `reg_wdata_o`.
- R4: With auto-increment on, each written word advances the pointer by one, wrapping from 16'hFFFF to 16'h0000.
- R5: In a read (address byte bit 0 = 1), each word goes out MSB first, high byte then low byte. A host ACK after the low byte continues the burst. A host NACK ends it, and the target releases the line.
- R6: With auto-increment on, successive words of a read burst come from consecutive addresses, starting at the pointer set in the write phase.
- R7: Writing a word to `CTRL_ADDR` sets auto-increment to bit 0 of that word; the pointer step that follows this one write uses the old setting. While auto-increment is off, all words of a burst write to, or read from, the same register.
- R8: While `mode_strap_i` is high, the target never pulls the data line low and never writes, whatever the bus does.
- R9: A repeated START restarts the byte sequence at the pointer high byte and discards any partial data word. The pointer keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_strap_i | input | 1 | Interface select; low enables this target |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls the data line low (open drain) |
| reg_addr_o | output | 16 | Register pointer |
| reg_wdata_o | output | 16 | Write data word |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_rdata_i | input | 16 | Read data at `reg_addr_o` |

## Verification
A wrong pointer or a wrong byte index inside the target shows up at the ports within one word time: a write lands at the wrong address, and the next readback of that address over the bus returns the wrong value. A wrong auto-increment state shows on the second word of any burst, through repeated or skipped addresses. A decode slip in the address byte shows at once, as an ack bit with the wrong polarity. Strobe count and line drive are also watched on every clock, so a spurious write or a pull-down while the strap is high is caught on the cycle it happens.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_TXACK,
    ST_SKIP
  } tgt_state_e;
endpackage

// File: rtl/i2c_sync.sv
module i2c_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= RST_VAL;
      else if (s == 0) stg[s] <= d_i;
      else stg[s] <= stg[(s == 0) ? 0 : s - 1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/i2c_line_events.sv
module i2c_line_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  // data edges while clock held high
  assign start_o = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_reg_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h1A,
  parameter logic [15:0] CTRL_ADDR   = 16'h0040,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        mode_strap_i,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe_o,
  output logic [15:0] reg_addr_o,
  output logic [15:0] reg_wdata_o,
  output logic        reg_we_o,
  input  logic [15:0] reg_rdata_i
);
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);

  logic [1:0] line_s;
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;

  i2c_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (line_s)
  );
  assign {scl_s, sda_s} = line_s;

  i2c_line_events u_evt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_s),
    .sda_i     (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_evt),
    .stop_o    (stop_evt)
  );

  tgt_state_e        state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg, data_hi, tx_lo;
  logic [1:0]        byte_idx;
  logic [15:0]       addr, wdata_q;
  logic              to_tx, byte_sel, nack_q, we_q, auto_inc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      data_hi  <= '0;
      tx_lo    <= '0;
      byte_idx <= '0;
      addr     <= '0;
      wdata_q  <= '0;
      to_tx    <= 1'b0;
      byte_sel <= 1'b0;
      nack_q   <= 1'b0;
      we_q     <= 1'b0;
      auto_inc <= 1'b1;
    end else begin
      we_q <= 1'b0;
      // pointer step after a write uses the setting in force before it
      if (we_q) begin
        if (auto_inc) addr <= addr + 16'd1;
        if (addr == CTRL_ADDR) auto_inc <= wdata_q[0];
      end
      if (mode_strap_i) begin
        state <= ST_IDLE;
      end else if (start_evt) begin
        state    <= ST_DEV;
        bit_cnt  <= '0;
        byte_idx <= '0;
      end else if (stop_evt) begin
        state <= ST_IDLE;
      end else begin
        unique case (state)
          ST_DEV, ST_RX: begin
            if (scl_rise) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == FULL_CNT) begin
              bit_cnt <= '0;
              if (state == ST_DEV) begin
                if (shreg[7:1] == DEV_ADDR) begin
                  state <= ST_ACK;
                  to_tx <= shreg[0];
                end else begin
                  state <= ST_SKIP;
                end
              end else begin
                state <= ST_ACK;
                to_tx <= 1'b0;
                unique case (byte_idx)
                  2'd0: addr[15:8] <= shreg;
                  2'd1: addr[7:0]  <= shreg;
                  2'd2: data_hi    <= shreg;
                  default: begin
                    we_q    <= 1'b1;
                    wdata_q <= {data_hi, shreg};
                  end
                endcase
                byte_idx <= (byte_idx == 2'd3) ? 2'd2 : byte_idx + 2'd1;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (to_tx) begin
                state    <= ST_TX;
                shreg    <= reg_rdata_i[15:8];
                tx_lo    <= reg_rdata_i[7:0];
                byte_sel <= 1'b0;
              end else begin
                state <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bit_cnt == LAST_BIT) begin
                state <= ST_TXACK;
              end else begin
                shreg   <= {shreg[BYTE_W-2:0], 1'b0};
                bit_cnt <= bit_cnt + 1'b1;
              end
            end
          end
          ST_TXACK: begin
            if (scl_rise) begin
              nack_q <= sda_s;
              if (!sda_s && byte_sel && auto_inc) addr <= addr + 16'd1;
            end else if (scl_fall) begin
              bit_cnt <= '0;
              if (nack_q) begin
                state <= ST_SKIP;
              end else begin
                state <= ST_TX;
                if (!byte_sel) begin
                  shreg    <= tx_lo;
                  byte_sel <= 1'b1;
                end else begin
                  shreg    <= reg_rdata_i[15:8];
                  tx_lo    <= reg_rdata_i[7:0];
                  byte_sel <= 1'b0;
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o    = (state == ST_ACK) | ((state == ST_TX) & ~shreg[BYTE_W-1]);
  assign reg_addr_o  = addr;
  assign reg_wdata_o = wdata_q;
  assign reg_we_o    = we_q;

  p_spi_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_strap_i |=> !sda_oe_o);
  p_we_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);
  p_addr_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o && auto_inc) |=> (reg_addr_o == $past(reg_addr_o) + 16'd1));
  p_addr_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o && !auto_inc) |=> $stable(reg_addr_o));
  p_start_release_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_evt && !mode_strap_i) |=> !sda_oe_o);
endmodule

// File: tb/sim_i2c_reg_target.sv
`timescale 1ns/1ps
module sim_i2c_reg_target;
  localparam logic [6:0]  DEV  = 7'h1A;
  localparam logic [15:0] CTRL = 16'h0040;
  localparam int Q = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap = 1'b0;
  logic scl = 1'b1;
  logic sda_h = 1'b1;
  logic sda_oe;
  logic [15:0] raddr, wdata, rdata;
  logic we;
  wire  sda_line = sda_h & ~sda_oe;

  always #5 clk = ~clk;

  i2c_reg_target #(.DEV_ADDR(DEV), .CTRL_ADDR(CTRL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_strap_i(strap), .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .reg_addr_o(raddr), .reg_wdata_o(wdata), .reg_we_o(we),
    .reg_rdata_i(rdata)
  );

  logic [15:0] rf [256];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) rf[i] <= '0;
    end else if (we) begin
      rf[raddr[7:0]] <= wdata;
    end
  end
  assign rdata = rf[raddr[7:0]];

  int we_seen = 0, oe_spi = 0;
  always @(posedge clk) begin
    if (we) we_seen <= we_seen + 1;
    if (strap && sda_oe) oe_spi <= oe_spi + 1;
  end

  logic [15:0] exp_mem [256];
  logic exp_ai = 1'b1;
  int exp_we = 0;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  function automatic logic [15:0] nxt(input logic [15:0] a, input logic ai);
    return ai ? a + 16'd1 : a;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hstart();
    sda_h = 1'b1; tk(Q); scl = 1'b1; tk(Q); sda_h = 1'b0; tk(Q); scl = 1'b0; tk(Q);
  endtask

  task automatic hstop();
    sda_h = 1'b0; tk(Q); scl = 1'b1; tk(Q); sda_h = 1'b1; tk(Q);
  endtask

  task automatic bit_w(input logic b);
    sda_h = b; tk(Q); scl = 1'b1; tk(2 * Q); scl = 1'b0; tk(Q);
  endtask

  task automatic bit_r(output logic b);
    sda_h = 1'b1; tk(Q); scl = 1'b1; tk(Q); b = sda_line; tk(Q); scl = 1'b0; tk(Q);
  endtask

  task automatic byte_w(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) bit_w(v[i]);
    bit_r(ack);
  endtask

  task automatic byte_r(output logic [7:0] v, input logic nack);
    logic b;
    for (int i = 7; i >= 0; i--) begin bit_r(b); v[i] = b; end
    bit_w(nack);
  endtask

  task automatic wr_words(input logic [15:0] a, input int n, input string req,
                          input logic use_fix, input logic [15:0] fix);
    logic ack; int nk = 0; logic [15:0] ea = a; logic [15:0] w; logic old;
    hstart();
    byte_w({DEV, 1'b0}, ack); nk += int'(ack);
    byte_w(a[15:8], ack); nk += int'(ack);
    byte_w(a[7:0], ack); nk += int'(ack);
    for (int i = 0; i < n; i++) begin
      w = use_fix ? fix + 16'(i) : 16'($urandom);
      byte_w(w[15:8], ack); nk += int'(ack);
      byte_w(w[7:0], ack); nk += int'(ack);
      exp_mem[ea[7:0]] = w;
      old = exp_ai;
      if (ea == CTRL) exp_ai = w[0];
      ea = nxt(ea, old);
    end
    hstop();
    exp_we += n;
    tk(4);
    check({req, " acks"}, nk, 0);
    check({req, " R3 strobes"}, we_seen, exp_we);
  endtask

  task automatic rd_words(input logic [15:0] a, input int n, input string req);
    logic ack; int nk = 0; logic [7:0] hi, lo; logic [15:0] ea = a;
    hstart();
    byte_w({DEV, 1'b0}, ack); nk += int'(ack);
    byte_w(a[15:8], ack); nk += int'(ack);
    byte_w(a[7:0], ack); nk += int'(ack);
    hstart();
    byte_w({DEV, 1'b1}, ack); nk += int'(ack);
    for (int i = 0; i < n; i++) begin
      byte_r(hi, 1'b0);
      byte_r(lo, (i == n - 1));
      check(req, {hi, lo}, exp_mem[ea[7:0]]);
      ea = nxt(ea, exp_ai);
    end
    check({req, " acks"}, nk, 0);
    tk(2);
    check("R5 released after NACK", sda_oe, 0);
    hstop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic ack; int nk; logic [15:0] a; int n;
    void'($urandom(32'h5eed));
    for (int i = 0; i < 256; i++) exp_mem[i] = '0;
    tk(3);
    check("R1 sda released", sda_oe, 0);
    check("R1 pointer", raddr, 0);
    check("R1 strobe", we, 0);
    rst_n = 1'b1;
    tk(5);

    // R1 R4 R6: default auto-increment burst
    wr_words(16'h0010, 3, "R4 burst write", 1'b1, 16'hA5C0);
    rd_words(16'h0010, 3, "R6 burst read");
    for (int i = 0; i < 3; i++) rd_words(16'h0010 + 16'(i), 1, "R4 single read");

    // R4 wrap
    wr_words(16'hFFFF, 2, "R4 wrap", 1'b1, 16'h0F0F);
    rd_words(16'h0000, 1, "R4 wrap to zero");
    rd_words(16'hFFFF, 2, "R6 read wrap");

    // R2 wrong device address
    hstart();
    byte_w({DEV ^ 7'h01, 1'b0}, ack);
    check("R2 address NACK", ack, 1);
    nk = 0;
    byte_w(8'h00, ack); nk += int'(ack);
    byte_w(8'h10, ack); nk += int'(ack);
    byte_w(8'hDE, ack); nk += int'(ack);
    byte_w(8'hAD, ack); nk += int'(ack);
    hstop(); tk(4);
    check("R2 bytes not acked", nk, 4);
    check("R2 no write", we_seen, exp_we);
    rd_words(16'h0010, 1, "R2 contents kept");

    // R9 repeated START drops partial word
    hstart();
    byte_w({DEV, 1'b0}, ack);
    byte_w(8'h00, ack); byte_w(8'h20, ack); byte_w(8'hAB, ack);
    hstart();
    byte_w({DEV, 1'b0}, ack);
    byte_w(8'h00, ack); byte_w(8'h21, ack);
    byte_w(8'h12, ack); byte_w(8'h34, ack);
    hstop(); tk(4);
    exp_mem[8'h21] = 16'h1234; exp_we++;
    check("R9 single write", we_seen, exp_we);
    rd_words(16'h0020, 2, "R9 readback");

    // R7 auto-increment off
    wr_words(CTRL, 1, "R7 disable", 1'b1, 16'h0000);
    check("R7 model off", exp_ai, 0);
    wr_words(16'h0030, 3, "R7 fixed write", 1'b1, 16'h7000);
    rd_words(16'h0030, 3, "R7 fixed read");
    rd_words(16'h0031, 1, "R7 neighbour untouched");
    wr_words(CTRL, 1, "R7 enable", 1'b1, 16'h0001);
    wr_words(16'h0032, 2, "R7 stepping again", 1'b1, 16'h3300);
    rd_words(16'h0032, 2, "R7 step read");

    // R8 strap high
    strap = 1'b1; tk(4);
    hstart(); nk = 0;
    byte_w({DEV, 1'b0}, ack); nk += int'(ack);
    byte_w(8'h00, ack); nk += int'(ack);
    byte_w(8'h50, ack); nk += int'(ack);
    byte_w(8'hBE, ack); nk += int'(ack);
    byte_w(8'hEF, ack); nk += int'(ack);
    hstop(); tk(4);
    check("R8 no acks", nk, 5);
    check("R8 no drive", oe_spi, 0);
    check("R8 no write", we_seen, exp_we);
    strap = 1'b0; tk(4);
    rd_words(16'h0050, 1, "R8 contents kept");

    // random bursts
    for (int k = 0; k < 10; k++) begin
      a = 16'($urandom);
      if (a[15:8] == 8'h00) a[15:8] = 8'h80;
      n = 1 + int'($urandom % 3);
      wr_words(a, n, "R3 random write", 1'b0, 16'h0);
      rd_words(a, n, "R5 random read");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule